// File: doc/BRIEF.md
# CPU Injection Frame Formatter

This block turns one frame, made of an internal frame header and a payload of a given byte length, into the ordered list of register writes that pushes that frame into a switch's CPU injection queue. Each write is presented on a valid/ready port. A flag selects the control register or the data register, and a 32-bit word carries the value. The header and payload words come in as one ordered word stream, header first, on a separate valid/ready input.

A frame starts with a one-cycle start pulse. The pulse carries the header word count and the payload length in bytes, and the block latches both. It then writes the start control word, the header words and the payload words. Zero words pad the payload up to a minimum cell of 60 bytes. An end control word follows, and one zero placeholder CRC word closes the frame. The busy flag covers the whole frame, including the time the last write waits for acceptance. Address decoding and the switch datapath are outside this block.

Top module: `cpu_inj_formatter`

## Requirements
- R1: The first write of a frame goes to the control register (is_ctrl = 1). Its value is 0x0024_0000: the gap-size field starting at bit 21 holds 1 and the start flag at bit 18 is set.
- R2: After the start control word, exactly the latched number of header words pass from the input stream to the data register (is_ctrl = 0), in order and unchanged.
- R3: After the header, ceil(length/4) payload words pass from the input stream to the data register, in order and unchanged.
- R4: When fewer than 15 payload words were written, zero data words follow until 15 body words in total have been written. At 15 or more payload words, no padding is added.
- R5: After the body comes one control write of 0x0028_0000 | (vb << 16): gap size 1, end flag at bit 19, and a 2-bit valid-bytes field vb at bits 17:16. vb is length mod 4 when length >= 60 and 0 otherwise. The start flag is clear in this word.
- R6: The last write of a frame is a single zero word to the data register.
- R7: A presented write that is not accepted keeps its valid, flag and data unchanged in the next cycle.
- R8: busy rises in the cycle after a start is accepted and falls in the cycle after the final CRC write is accepted. A start pulse while busy is ignored and does not alter the frame in progress.
- R9: After reset, no write is presented, busy is low and no input word is taken.
- R10: The block takes exactly header count + ceil(length/4) words from the input stream per frame, and takes none while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted when busy is low |
| hdr_words_i | input | HDR_W | Header word count, latched at start |
| byte_len_i | input | LEN_W | Payload length in bytes, latched at start |
| busy_o | output | 1 | Frame in progress or final write not yet accepted |
| in_valid_i | input | 1 | Input stream word valid |
| in_ready_o | output | 1 | Input stream word taken |
| in_data_i | input | 32 | Header or payload word |
| wr_valid_o | output | 1 | Register write presented |
| wr_ready_i | input | 1 | Register write accepted |
| wr_is_ctrl_o | output | 1 | 1: control register, 0: data register |
| wr_data_o | output | 32 | Write value |

## Verification
The assertions check the properties that hold on every cycle. A stalled write must stay unchanged, and no write may appear while busy is low. The input stream must stay untouched when idle. The first write after a start must be the start control word, no later control word may carry the start flag, and busy may fall only right after a zero data write was accepted. The bench's scenarios are the only way to show the full order and content of the writes: header and payload pass-through, the exact amount of padding, the length-dependent valid-bytes field, and the number of input words consumed. The bench sweeps header counts and lengths on both sides of the 60-byte boundary, with and without stalls on both sides, and issues a start in the middle of a frame.

// File: rtl/cif_pkg.sv
// Package: shared types and control-word construction for the CPU injection
// frame formatter. Assumes a 32-bit register bus.
package cif_pkg;

    localparam int unsigned DW          = 32;
    localparam int unsigned GAP_LSB     = 21;
    localparam int unsigned GAP_W       = 4;
    localparam int unsigned EOF_BIT     = 19;
    localparam int unsigned SOF_BIT     = 18;
    localparam int unsigned VB_LSB      = 16;
    localparam logic [GAP_W-1:0] GAP_VAL = 4'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF,
        ST_HDR,
        ST_BODY,
        ST_EOF,
        ST_CRC
    } seq_state_t;

    // Build a control-register value from its fields.
    function automatic logic [DW-1:0] ctrl_word(input logic sof, input logic eof,
                                                input logic [1:0] vb);
        logic [DW-1:0] w;
        w = '0;
        w[GAP_LSB +: GAP_W] = GAP_VAL;
        w[EOF_BIT]          = eof;
        w[SOF_BIT]          = sof;
        w[VB_LSB +: 2]      = vb;
        return w;
    endfunction

endpackage

// File: rtl/cif_frame_plan.sv
// Frame plan: latches header count and byte length at start and derives the
// payload word count, the padded body word count and the valid-bytes value.
// Assumes load is only asserted while no frame is in progress.
module cif_frame_plan #(
    parameter int unsigned HDR_W          = 4,
    parameter int unsigned LEN_W          = 11,
    parameter int unsigned MIN_CELL_BYTES = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [HDR_W-1:0] hdr_words_i,
    input  logic [LEN_W-1:0] byte_len_i,
    output logic [HDR_W-1:0] hdr_cnt_o,
    output logic [LEN_W-1:0] pay_words_o,
    output logic [LEN_W-1:0] body_words_o,
    output logic [1:0]       vb_o
);

    localparam int unsigned MIN_WORDS = MIN_CELL_BYTES / 4;
    localparam logic [LEN_W-1:0] MIN_WORDS_L = LEN_W'(MIN_WORDS);
    localparam logic [LEN_W-1:0] MIN_BYTES_L = LEN_W'(MIN_CELL_BYTES);

    logic [HDR_W-1:0] hdr_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W:0]   words_ext;

    // Latch frame parameters at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q <= '0;
            len_q <= '0;
        end else if (load_i) begin
            hdr_q <= hdr_words_i;
            len_q <= byte_len_i;
        end
    end

    // Derive word counts and the valid-bytes value from latched length.
    always_comb begin
        words_ext    = ({1'b0, len_q} + (LEN_W+1)'(3)) >> 2;
        pay_words_o  = words_ext[LEN_W-1:0];
        body_words_o = (pay_words_o < MIN_WORDS_L) ? MIN_WORDS_L : pay_words_o;
        vb_o         = (len_q >= MIN_BYTES_L) ? len_q[1:0] : 2'd0;
        hdr_cnt_o    = hdr_q;
    end

endmodule

// File: rtl/cif_sequencer.sv
// Sequencer: walks start control, header, body (payload then zero pad), end
// control and CRC phases, generating one write per accepted cycle.
// Assumes gen_ready_i reflects space in the output register.
module cif_sequencer
    import cif_pkg::*;
#(
    parameter int unsigned HDR_W = 4,
    parameter int unsigned LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             idle_o,
    input  logic [HDR_W-1:0] hdr_cnt_i,
    input  logic [LEN_W-1:0] pay_words_i,
    input  logic [LEN_W-1:0] body_words_i,
    input  logic [1:0]       vb_i,
    input  logic             in_valid_i,
    input  logic [DW-1:0]    in_data_i,
    output logic             in_ready_o,
    output logic             gen_valid_o,
    output logic             gen_ctrl_o,
    output logic [DW-1:0]    gen_data_o,
    input  logic             gen_ready_i
);

    seq_state_t       state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic [LEN_W-1:0] cnt_inc;
    logic             take_in;
    logic             fire;

    assign cnt_inc = cnt_q + LEN_W'(1);
    assign idle_o  = (state_q == ST_IDLE);

    // Select the write for the current phase.
    always_comb begin
        gen_valid_o = 1'b0;
        gen_ctrl_o  = 1'b0;
        gen_data_o  = '0;
        take_in     = 1'b0;
        unique case (state_q)
            ST_SOF: begin
                gen_valid_o = 1'b1;
                gen_ctrl_o  = 1'b1;
                gen_data_o  = ctrl_word(1'b1, 1'b0, 2'd0);
            end
            ST_HDR: begin
                take_in     = 1'b1;
                gen_valid_o = in_valid_i;
                gen_data_o  = in_data_i;
            end
            ST_BODY: begin
                if (cnt_q < pay_words_i) begin
                    take_in     = 1'b1;
                    gen_valid_o = in_valid_i;
                    gen_data_o  = in_data_i;
                end else begin
                    gen_valid_o = 1'b1;
                end
            end
            ST_EOF: begin
                gen_valid_o = 1'b1;
                gen_ctrl_o  = 1'b1;
                gen_data_o  = ctrl_word(1'b0, 1'b1, vb_i);
            end
            ST_CRC: begin
                gen_valid_o = 1'b1;
            end
            default: begin
                gen_valid_o = 1'b0;
            end
        endcase
    end

    assign fire       = gen_valid_o && gen_ready_i;
    assign in_ready_o = take_in && gen_ready_i;

    // Phase and counter transitions on each accepted write.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_SOF;
                    cnt_d   = '0;
                end
            end
            ST_SOF: begin
                if (fire) begin
                    cnt_d   = '0;
                    state_d = (hdr_cnt_i == '0) ? ST_BODY : ST_HDR;
                end
            end
            ST_HDR: begin
                if (fire) begin
                    if (cnt_inc == LEN_W'(hdr_cnt_i)) begin
                        cnt_d   = '0;
                        state_d = ST_BODY;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
            end
            ST_BODY: begin
                if (fire) begin
                    cnt_d = cnt_inc;
                    if (cnt_inc == body_words_i) state_d = ST_EOF;
                end
            end
            ST_EOF: begin
                if (fire) state_d = ST_CRC;
            end
            ST_CRC: begin
                if (fire) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/cif_out_stage.sv
// Output stage: one register holding the presented write. It loads a new
// write only when empty or when the held write is accepted, so a stalled
// write stays unchanged.
module cif_out_stage
    import cif_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gen_valid_i,
    input  logic          gen_ctrl_i,
    input  logic [DW-1:0] gen_data_i,
    output logic          gen_ready_o,
    output logic          wr_valid_o,
    output logic          wr_is_ctrl_o,
    output logic [DW-1:0] wr_data_o,
    input  logic          wr_ready_i
);

    logic          v_q;
    logic          c_q;
    logic [DW-1:0] d_q;

    assign gen_ready_o  = !v_q || wr_ready_i;
    assign wr_valid_o   = v_q;
    assign wr_is_ctrl_o = c_q;
    assign wr_data_o    = d_q;

    // Hold or refill the presented write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= 1'b0;
            c_q <= 1'b0;
            d_q <= '0;
        end else if (gen_ready_o) begin
            v_q <= gen_valid_i;
            c_q <= gen_valid_i ? gen_ctrl_i : 1'b0;
            d_q <= gen_valid_i ? gen_data_i : '0;
        end
    end

endmodule

// File: rtl/cpu_inj_formatter.sv
// Top: CPU injection frame formatter. Accepts a start pulse with header word
// count and byte length, consumes header and payload words from a stream and
// presents the ordered register writes on a valid/ready port.
// Assumes header words precede payload words on the input stream.
module cpu_inj_formatter
    import cif_pkg::*;
#(
    parameter int unsigned HDR_W          = 4,
    parameter int unsigned LEN_W          = 11,
    parameter int unsigned MIN_CELL_BYTES = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [HDR_W-1:0] hdr_words_i,
    input  logic [LEN_W-1:0] byte_len_i,
    output logic             busy_o,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    input  logic [31:0]      in_data_i,
    output logic             wr_valid_o,
    input  logic             wr_ready_i,
    output logic             wr_is_ctrl_o,
    output logic [31:0]      wr_data_o
);

    logic             seq_idle;
    logic             start_acc;
    logic [HDR_W-1:0] hdr_cnt;
    logic [LEN_W-1:0] pay_words;
    logic [LEN_W-1:0] body_words;
    logic [1:0]       vb;
    logic             gen_valid;
    logic             gen_ctrl;
    logic [DW-1:0]    gen_data;
    logic             gen_ready;

    // Busy covers the sequence and the last write awaiting acceptance.
    assign busy_o    = !seq_idle || wr_valid_o;
    assign start_acc = start_i && !busy_o;

    cif_frame_plan #(
        .HDR_W          (HDR_W),
        .LEN_W          (LEN_W),
        .MIN_CELL_BYTES (MIN_CELL_BYTES)
    ) u_plan (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (start_acc),
        .hdr_words_i  (hdr_words_i),
        .byte_len_i   (byte_len_i),
        .hdr_cnt_o    (hdr_cnt),
        .pay_words_o  (pay_words),
        .body_words_o (body_words),
        .vb_o         (vb)
    );

    cif_sequencer #(
        .HDR_W (HDR_W),
        .LEN_W (LEN_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_acc),
        .idle_o       (seq_idle),
        .hdr_cnt_i    (hdr_cnt),
        .pay_words_i  (pay_words),
        .body_words_i (body_words),
        .vb_i         (vb),
        .in_valid_i   (in_valid_i),
        .in_data_i    (in_data_i),
        .in_ready_o   (in_ready_o),
        .gen_valid_o  (gen_valid),
        .gen_ctrl_o   (gen_ctrl),
        .gen_data_o   (gen_data),
        .gen_ready_i  (gen_ready)
    );

    cif_out_stage u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .gen_valid_i  (gen_valid),
        .gen_ctrl_i   (gen_ctrl),
        .gen_data_i   (gen_data),
        .gen_ready_o  (gen_ready),
        .wr_valid_o   (wr_valid_o),
        .wr_is_ctrl_o (wr_is_ctrl_o),
        .wr_data_o    (wr_data_o),
        .wr_ready_i   (wr_ready_i)
    );

endmodule

// File: rtl/cif_checker.sv
// Checker: port-level properties of the formatter, bound to the top module.
module cif_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        in_ready_o,
    input logic        wr_valid_o,
    input logic        wr_ready_i,
    input logic        wr_is_ctrl_o,
    input logic [31:0] wr_data_o
);

    logic first_pend;

    // Track whether the first write of an accepted frame is still due.
    always_ff @(posedge clk) begin
        if (!rst_n)                         first_pend <= 1'b0;
        else if (start_i && !busy_o)        first_pend <= 1'b1;
        else if (wr_valid_o && wr_ready_i)  first_pend <= 1'b0;
    end

    AST_FIRST_IS_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && first_pend) |-> (wr_is_ctrl_o && wr_data_o == 32'h0024_0000)); // R1

    AST_NO_LATE_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !first_pend && wr_is_ctrl_o) |-> !wr_data_o[18]); // R5

    AST_HOLD_UNDER_BP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_is_ctrl_o) && $stable(wr_data_o))); // R7

    AST_VALID_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> busy_o); // R8

    AST_BUSY_ENDS_ON_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(wr_valid_o && wr_ready_i && !wr_is_ctrl_o && wr_data_o == 32'h0)); // R6

    AST_IDLE_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !in_ready_o); // R10

endmodule

bind cpu_inj_formatter cif_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .in_ready_o   (in_ready_o),
    .wr_valid_o   (wr_valid_o),
    .wr_ready_i   (wr_ready_i),
    .wr_is_ctrl_o (wr_is_ctrl_o),
    .wr_data_o    (wr_data_o)
);

// File: tb/cpu_inj_formatter_tb.sv
module cpu_inj_formatter_tb;

    localparam int HDR_W = 4;
    localparam int LEN_W = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [HDR_W-1:0] hdr_words_i = '0;
    logic [LEN_W-1:0] byte_len_i = '0;
    logic             busy_o;
    logic             in_valid_i = 1'b0;
    logic             in_ready_o;
    logic [31:0]      in_data_i = '0;
    logic             wr_valid_o;
    logic             wr_ready_i = 1'b0;
    logic             wr_is_ctrl_o;
    logic [31:0]      wr_data_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int bp_mode = 0;
    int src_n = 0;
    int src_idx = 0;
    int n_rec = 0;
    logic [31:0] src [0:63];
    logic [31:0] rec_d [0:63];
    logic        rec_c [0:63];
    logic        prev_stall = 1'b0;
    logic        prev_c = 1'b0;
    logic [31:0] prev_d = '0;

    always #10 clk = ~clk;

    cpu_inj_formatter #(.HDR_W(HDR_W), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .hdr_words_i(hdr_words_i),
        .byte_len_i(byte_len_i), .busy_o(busy_o), .in_valid_i(in_valid_i),
        .in_ready_o(in_ready_o), .in_data_i(in_data_i), .wr_valid_o(wr_valid_o),
        .wr_ready_i(wr_ready_i), .wr_is_ctrl_o(wr_is_ctrl_o), .wr_data_o(wr_data_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Drive stream and ready, then record handshakes due at the next edge.
    always begin
        @(negedge clk);
        cyc++;
        wr_ready_i = (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        in_valid_i = (src_idx < src_n) && ((bp_mode == 0) || ((cyc % 4) != 1));
        in_data_i  = (src_idx < 64) ? src[src_idx] : 32'h0;
        #1;
        if (prev_stall && rst_n) // R7
            check(wr_valid_o && wr_is_ctrl_o == prev_c && wr_data_o == prev_d,
                  "R7", wr_data_o, prev_d);
        prev_stall = wr_valid_o && !wr_ready_i;
        prev_c = wr_is_ctrl_o;
        prev_d = wr_data_o;
        if (wr_valid_o && wr_ready_i) begin
            if (n_rec < 64) begin
                rec_d[n_rec] = wr_data_o;
                rec_c[n_rec] = wr_is_ctrl_o;
            end
            n_rec++;
        end
        if (in_valid_i && in_ready_o) src_idx++;
    end

    // Watchdog.
    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL watchdog: actual %0d expected 0", 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic run_frame(input int hdr, input int len, input int mode, input bit poke);
        int pw, bw, exp_n, k, vb, waitc;
        logic [31:0] e_d [0:63];
        logic        e_c [0:63];
        string req;
        bit bad;
        pw = (len + 3) / 4;
        bw = (pw < 15) ? 15 : pw;
        vb = (len >= 60) ? (len % 4) : 0;
        for (int i = 0; i < hdr + pw; i++)
            src[i] = 32'h5A00_0000 ^ {8'(hdr), 8'(len), 16'(i + 1)};
        @(negedge clk);
        bp_mode = mode;
        src_idx = 0;
        src_n = hdr + pw;
        n_rec = 0;
        // expected write list
        exp_n = 0;
        e_c[exp_n] = 1'b1; e_d[exp_n] = 32'h0024_0000; exp_n++;
        for (int i = 0; i < hdr + pw; i++) begin
            e_c[exp_n] = 1'b0; e_d[exp_n] = src[i]; exp_n++;
        end
        for (int i = pw; i < bw; i++) begin
            e_c[exp_n] = 1'b0; e_d[exp_n] = 32'h0; exp_n++;
        end
        e_c[exp_n] = 1'b1; e_d[exp_n] = 32'h0028_0000 | (32'(vb) << 16); exp_n++;
        e_c[exp_n] = 1'b0; e_d[exp_n] = 32'h0; exp_n++;
        start_i = 1'b1; hdr_words_i = HDR_W'(hdr); byte_len_i = LEN_W'(len);
        @(negedge clk);
        start_i = 1'b0;
        #2;
        check(busy_o, "R8", 32'(busy_o), 32'h1);
        if (poke) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1; hdr_words_i = 4'd7; byte_len_i = 11'd100;
            @(negedge clk);
            start_i = 1'b0;
        end
        waitc = 0;
        while (busy_o && waitc < 400) begin
            @(negedge clk); #2; waitc++;
        end
        check(n_rec == exp_n, "R8", 32'(n_rec), 32'(exp_n));
        check(src_idx == hdr + pw, "R10", 32'(src_idx), 32'(hdr + pw));
        bad = 1'b0;
        for (int i = 0; i < exp_n && i < n_rec && !bad; i++) begin
            if (rec_c[i] !== e_c[i] || rec_d[i] !== e_d[i]) begin
                bad = 1'b1;
                k = i;
            end
        end
        if (bad) begin
            if (k == 0) req = "R1";
            else if (k <= hdr) req = "R2";
            else if (k <= hdr + pw) req = "R3";
            else if (k <= hdr + bw) req = "R4";
            else if (k == hdr + bw + 1) req = "R5";
            else req = "R6";
            check(1'b0, req, rec_d[k], e_d[k]);
        end else begin
            check(1'b1, "R1 R2 R3 R4 R5 R6", 0, 0);
        end
        // nothing more may be consumed while idle
        repeat (2) @(negedge clk);
        #2;
        check(!in_ready_o && !wr_valid_o, "R10", 32'(in_ready_o), 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) src[i] = '0;
        repeat (3) @(negedge clk);
        #2;
        check(!wr_valid_o && !busy_o && !in_ready_o, "R9",
              {29'd0, wr_valid_o, busy_o, in_ready_o}, 32'h0);
        rst_n = 1'b1;
        for (int mode = 0; mode < 2; mode++)
            for (int hdr = 0; hdr < 4; hdr++)
                for (int len = 0; len <= 70; len++)
                    run_frame(hdr, len, mode, 1'b0);
        run_frame(2, 63, 1, 1'b1); // R8: start while busy ignored
        run_frame(0, 61, 0, 1'b1); // R8
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule